// File: doc/BRIEF.md
# Outstanding Read Tracker with Speculative Merge

This block sits between a core's load path and its first cache level. It records every line-granular read that is in flight. It decides for each new read whether to send it downstream, attach it to a read already in flight, or turn it back for a retry. A new read to a line with nothing outstanding claims a free slot and is issued at once. A speculative load to a line that already has an outstanding speculative load is attached to that slot's list of dependents and is not sent again. Every other collision is turned back as aliased, and a counter of such load-behind-load conflicts advances.

When the cache returns the line, the block latches the whole line and hands back completions one at a time on a valid/ready port. The original request comes first, followed by each attached request in the order it arrived. Each completion carries the bytes at its own offset and size, and speculative completions are flagged as local hits when the data did not come from beyond the local level. Expose and validate requests use the same tracking. Expose leaves without a data payload, and neither returns load data. A slot is released only when its last completion is taken.

Top module: `ort_read_table`

## Requirements
- R1: After reset there is no completion pending (`cpl_valid` low), `rsp_ready` is high and `alias_count` is zero.
- R2: A request to a line with no tracked read and a free slot gets status 0 (ready). In the same cycle, `iss_valid` is high with `iss_line` equal to the request's line. Request kinds are: 0 load, 1 instruction fetch, 2 speculative load, 3 expose, 4 validate.
- R3: A speculative load (kind 2) to a line whose tracked read is a speculative load, whose response has not arrived, and whose dependent list is not full gets status 1 (merged) and causes no issue.
- R4: Any other request to a tracked line gets status 2 (aliased) and causes no issue. `alias_count` is one higher in the following cycle.
- R5: A slot holds at most DEPS (4) dependents, so a fifth merge attempt on the same line gets status 2.
- R6: With all ENTRIES (8) slots in use, a request to an untracked line gets status 3 (full) and causes no issue, and `alias_count` does not change.
- R7: After a response is accepted, completions appear one per accepted handshake, the primary first and then the dependents in arrival order. While `cpl_ready` is low, a completion is held unchanged.
- R8: Completion data byte j equals byte (offset+j) of the returned line for j below the request size, and is zero above it. Line byte k sits at `rsp_data[8k+7:8k]`.
- R9: `cpl_local_hit` is high exactly for speculative-load completions of a response with `rsp_external` low.
- R10: Expose requests issue with `iss_payload` low, while all other kinds issue with it high. Expose and validate completions have `cpl_has_data` low and all-zero data.
- R11: A slot is freed only by the handshake of its last completion. A request to that line in the same cycle is aliased, and in the next cycle it is ready.
- R12: A speculative load to a line whose response has been accepted but whose completions are still pending gets status 2.
- R13: `rsp_ready` is low while completions are pending. A response for a line that is not tracked is consumed without producing any completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | New read request present this cycle |
| req_kind | input | 3 | Request kind code (see R2) |
| req_addr | input | ADDR_W | Byte address of the request |
| req_size | input | SZ_W | Request size in bytes, 1 to MAX_BYTES |
| req_tag | input | TAG_W | Requester's identifier, returned with the completion |
| req_status | output | 2 | 0 ready, 1 merged, 2 aliased, 3 full; combinational |
| iss_valid | output | 1 | Request is sent downstream this cycle |
| iss_line | output | LINE_W | Line address sent downstream |
| iss_payload | output | 1 | Downstream request carries a data payload |
| rsp_valid | input | 1 | Line response present |
| rsp_ready | output | 1 | Block can accept a response |
| rsp_line | input | LINE_W | Line address of the response |
| rsp_data | input | 8*LINE_BYTES | Returned line contents |
| rsp_external | input | 1 | Data came from beyond the local cache level |
| cpl_valid | output | 1 | Completion present |
| cpl_ready | input | 1 | Core accepts the completion |
| cpl_tag | output | TAG_W | Identifier of the completed request |
| cpl_data | output | 8*MAX_BYTES | Load bytes, low byte first |
| cpl_has_data | output | 1 | Completion carries load data |
| cpl_local_hit | output | 1 | Speculative load served by the local level |
| alias_count | output | CNT_W | Count of aliased requests |

## Verification
The checks assume that at most one request arrives per cycle, that `offset + size` never crosses the end of a line, and that size is between 1 and MAX_BYTES. They also assume the completion payload is judged only while `cpl_valid` is high. The directed tests keep every request inside one line and drive a single request per cycle. They hold responses to a single cycle and look at completion fields only while valid is asserted. This keeps the stall-hold, counter-step and zero-data properties inside their premises. Stray responses are sent only when no slot tracks their line, which matches the consumed-and-dropped behaviour the design commits to.

// File: rtl/ort_pkg.sv
package ort_pkg;

    typedef enum logic [2:0] {
        K_LOAD     = 3'd0,
        K_IFETCH   = 3'd1,
        K_SPEC     = 3'd2,
        K_EXPOSE   = 3'd3,
        K_VALIDATE = 3'd4
    } rd_kind_e;

    typedef enum logic [1:0] {
        ST_READY   = 2'd0,
        ST_MERGED  = 2'd1,
        ST_ALIASED = 2'd2,
        ST_FULL    = 2'd3
    } rd_status_e;

    function automatic logic kind_is_spec(input logic [2:0] k);
        return k == K_SPEC;
    endfunction

    function automatic logic kind_has_payload(input logic [2:0] k);
        return k != K_EXPOSE;
    endfunction

    function automatic logic kind_returns_data(input logic [2:0] k);
        return (k != K_EXPOSE) && (k != K_VALIDATE);
    endfunction

endpackage

// File: rtl/ort_match.sv
module ort_match #(
    parameter int ENTRIES = 8,
    parameter int LINE_W  = 28,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]        vld,
    input  logic [ENTRIES*LINE_W-1:0] lines,
    input  logic [LINE_W-1:0]         probe,
    output logic                      hit,
    output logic [IDX_W-1:0]          hit_idx
);
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (vld[i] && (lines[i*LINE_W +: LINE_W] == probe)) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/ort_pick_free.sv
module ort_pick_free #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] vld,
    output logic               found,
    output logic [IDX_W-1:0]   idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!vld[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/ort_drain.sv
module ort_drain
    import ort_pkg::*;
#(
    parameter int LINE_BYTES = 16,
    parameter int MAX_BYTES  = 4,
    parameter int TAG_W      = 6,
    parameter int ENTRIES    = 8,
    parameter int DEPS       = 4,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int SZ_W      = $clog2(MAX_BYTES + 1),
    localparam int IDX_W     = $clog2(ENTRIES),
    localparam int DCNT_W    = $clog2(DEPS + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [IDX_W-1:0]        start_idx,
    input  logic [8*LINE_BYTES-1:0] start_data,
    input  logic                    start_ext,
    input  logic [TAG_W-1:0]        cur_tag,
    input  logic [2:0]              cur_kind,
    input  logic [OFF_W-1:0]        cur_off,
    input  logic [SZ_W-1:0]         cur_size,
    input  logic [DCNT_W-1:0]       cur_cnt,
    input  logic                    cpl_ready,
    output logic                    busy,
    output logic [IDX_W-1:0]        idx,
    output logic [DCNT_W-1:0]       pos,
    output logic                    done,
    output logic                    cpl_valid,
    output logic [TAG_W-1:0]        cpl_tag,
    output logic [8*MAX_BYTES-1:0]  cpl_data,
    output logic                    cpl_has_data,
    output logic                    cpl_local_hit
);
    logic [8*LINE_BYTES-1:0] line_q;
    logic                    ext_q;
    logic                    take;
    logic                    is_last;

    assign take    = busy && cpl_ready;
    assign is_last = (pos == cur_cnt);
    assign done    = take && is_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            idx  <= '0;
            pos  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            idx  <= start_idx;
            pos  <= '0;
        end else if (take) begin
            if (is_last) begin
                busy <= 1'b0;
            end else begin
                pos <= pos + DCNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (start) begin
            line_q <= start_data;
            ext_q  <= start_ext;
        end
    end

    assign cpl_valid     = busy;
    assign cpl_tag       = cur_tag;
    assign cpl_has_data  = kind_returns_data(cur_kind);
    assign cpl_local_hit = kind_is_spec(cur_kind) && !ext_q;

    always_comb begin
        int b;
        cpl_data = '0;
        for (int j = 0; j < MAX_BYTES; j++) begin
            b = int'(cur_off) + j;
            if (cpl_has_data && (j < int'(cur_size)) && (b < LINE_BYTES)) begin
                cpl_data[j*8 +: 8] = line_q[b*8 +: 8];
            end
        end
    end
endmodule

// File: rtl/ort_read_table.sv
module ort_read_table
    import ort_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int ENTRIES    = 8,
    parameter int DEPS       = 4,
    parameter int TAG_W      = 6,
    parameter int MAX_BYTES  = 4,
    parameter int CNT_W      = 16,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int LINE_W    = ADDR_W - OFF_W,
    localparam int SZ_W      = $clog2(MAX_BYTES + 1),
    localparam int IDX_W     = $clog2(ENTRIES),
    localparam int DCNT_W    = $clog2(DEPS + 1),
    localparam int DSL_W     = $clog2(DEPS)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    input  logic [2:0]              req_kind,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [SZ_W-1:0]         req_size,
    input  logic [TAG_W-1:0]        req_tag,
    output logic [1:0]              req_status,
    output logic                    iss_valid,
    output logic [LINE_W-1:0]       iss_line,
    output logic                    iss_payload,
    input  logic                    rsp_valid,
    output logic                    rsp_ready,
    input  logic [LINE_W-1:0]       rsp_line,
    input  logic [8*LINE_BYTES-1:0] rsp_data,
    input  logic                    rsp_external,
    output logic                    cpl_valid,
    input  logic                    cpl_ready,
    output logic [TAG_W-1:0]        cpl_tag,
    output logic [8*MAX_BYTES-1:0]  cpl_data,
    output logic                    cpl_has_data,
    output logic                    cpl_local_hit,
    output logic [CNT_W-1:0]        alias_count
);
    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [2:0]       kind;
        logic [OFF_W-1:0] off;
        logic [SZ_W-1:0]  size;
    } rec_t;

    // slot storage
    logic [ENTRIES-1:0]        ent_vld;
    logic [LINE_W-1:0]         ent_line [ENTRIES];
    rec_t                      ent_pri  [ENTRIES];
    rec_t                      ent_dep  [ENTRIES][DEPS];
    logic [DCNT_W-1:0]         ent_cnt  [ENTRIES];
    logic [ENTRIES*LINE_W-1:0] line_flat;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_flat
        assign line_flat[g*LINE_W +: LINE_W] = ent_line[g];
    end

    // request decode
    logic [LINE_W-1:0] req_line;
    rec_t              new_rec;
    assign req_line     = req_addr[ADDR_W-1:OFF_W];
    assign new_rec.tag  = req_tag;
    assign new_rec.kind = req_kind;
    assign new_rec.off  = req_addr[OFF_W-1:0];
    assign new_rec.size = req_size;

    logic             req_hit, rsp_hit, free_ok;
    logic [IDX_W-1:0] req_idx, rsp_idx, free_idx;

    ort_match #(.ENTRIES(ENTRIES), .LINE_W(LINE_W)) u_match_req (
        .vld(ent_vld), .lines(line_flat), .probe(req_line),
        .hit(req_hit), .hit_idx(req_idx)
    );

    ort_match #(.ENTRIES(ENTRIES), .LINE_W(LINE_W)) u_match_rsp (
        .vld(ent_vld), .lines(line_flat), .probe(rsp_line),
        .hit(rsp_hit), .hit_idx(rsp_idx)
    );

    ort_pick_free #(.ENTRIES(ENTRIES)) u_free (
        .vld(ent_vld), .found(free_ok), .idx(free_idx)
    );

    // drain engine interface
    logic              drn_busy, drn_done, rsp_take;
    logic [IDX_W-1:0]  drn_idx;
    logic [DCNT_W-1:0] drn_pos;
    rec_t              cur_rec;

    always_comb begin
        if (drn_pos == '0) begin
            cur_rec = ent_pri[drn_idx];
        end else begin
            cur_rec = ent_dep[drn_idx][DSL_W'(drn_pos - DCNT_W'(1))];
        end
    end

    // status decision
    rd_status_e status;
    logic       hit_draining;
    assign hit_draining = drn_busy && (drn_idx == req_idx);

    always_comb begin
        if (!req_hit) begin
            status = free_ok ? ST_READY : ST_FULL;
        end else if (kind_is_spec(req_kind) && kind_is_spec(ent_pri[req_idx].kind)
                     && !hit_draining && (ent_cnt[req_idx] < DCNT_W'(DEPS))) begin
            status = ST_MERGED;
        end else begin
            status = ST_ALIASED;
        end
    end

    logic do_alloc, do_merge, do_alias;
    assign do_alloc = req_valid && (status == ST_READY);
    assign do_merge = req_valid && (status == ST_MERGED);
    assign do_alias = req_valid && (status == ST_ALIASED);

    assign req_status  = status;
    assign iss_valid   = do_alloc;
    assign iss_line    = req_line;
    assign iss_payload = kind_has_payload(req_kind);

    assign rsp_ready = !drn_busy;
    assign rsp_take  = rsp_valid && !drn_busy && rsp_hit;

    // control state
    always_ff @(posedge clk) begin
        if (rst) begin
            ent_vld     <= '0;
            alias_count <= '0;
        end else begin
            if (do_alloc) ent_vld[free_idx] <= 1'b1;
            if (drn_done) ent_vld[drn_idx]  <= 1'b0;
            if (do_alias) alias_count <= alias_count + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) ent_cnt[i] <= '0;
        end else if (do_alloc) begin
            ent_cnt[free_idx] <= '0;
        end else if (do_merge) begin
            ent_cnt[req_idx] <= ent_cnt[req_idx] + DCNT_W'(1);
        end
    end

    // payload storage, no reset needed
    always_ff @(posedge clk) begin
        if (do_alloc) begin
            ent_line[free_idx] <= req_line;
            ent_pri[free_idx]  <= new_rec;
        end
        if (do_merge) begin
            ent_dep[req_idx][DSL_W'(ent_cnt[req_idx])] <= new_rec;
        end
    end

    ort_drain #(
        .LINE_BYTES(LINE_BYTES), .MAX_BYTES(MAX_BYTES), .TAG_W(TAG_W),
        .ENTRIES(ENTRIES), .DEPS(DEPS)
    ) u_drain (
        .clk(clk), .rst(rst),
        .start(rsp_take), .start_idx(rsp_idx),
        .start_data(rsp_data), .start_ext(rsp_external),
        .cur_tag(cur_rec.tag), .cur_kind(cur_rec.kind),
        .cur_off(cur_rec.off), .cur_size(cur_rec.size),
        .cur_cnt(ent_cnt[drn_idx]),
        .cpl_ready(cpl_ready),
        .busy(drn_busy), .idx(drn_idx), .pos(drn_pos), .done(drn_done),
        .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_data(cpl_data),
        .cpl_has_data(cpl_has_data), .cpl_local_hit(cpl_local_hit)
    );
endmodule

// File: rtl/ort_read_table_chk.sv
module ort_read_table_chk #(
    parameter int TAG_W     = 6,
    parameter int MAX_BYTES = 4,
    parameter int CNT_W     = 16
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   req_valid,
    input logic [1:0]             req_status,
    input logic                   iss_valid,
    input logic                   cpl_valid,
    input logic                   cpl_ready,
    input logic [TAG_W-1:0]       cpl_tag,
    input logic [8*MAX_BYTES-1:0] cpl_data,
    input logic                   cpl_has_data,
    input logic                   cpl_local_hit,
    input logic [CNT_W-1:0]       alias_count
);
    // R7: a stalled completion stays put
    a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
        cpl_valid && !cpl_ready |=> cpl_valid && $stable(cpl_tag) && $stable(cpl_data));

    // R4: aliased request steps the counter by one
    a_r4_alias_step: assert property (@(posedge clk) disable iff (rst)
        req_valid && (req_status == 2'd2) |=> alias_count == ($past(alias_count) + CNT_W'(1)));

    // R6: full status leaves the counter alone
    a_r6_full_no_count: assert property (@(posedge clk) disable iff (rst)
        req_valid && (req_status == 2'd3) |=> $stable(alias_count));

    // R3: only a ready status issues
    a_r3_no_issue_unless_ready: assert property (@(posedge clk) disable iff (rst)
        req_valid && (req_status != 2'd0) |-> !iss_valid);

    // R10: data-less completions carry zero bytes
    a_r10_nodata_zero: assert property (@(posedge clk) disable iff (rst)
        cpl_valid && !cpl_has_data |-> cpl_data == '0);

    // R9: a local hit is only reported on a data-bearing completion
    a_r9_hit_with_data: assert property (@(posedge clk) disable iff (rst)
        cpl_valid && cpl_local_hit |-> cpl_has_data);
endmodule

bind ort_read_table ort_read_table_chk #(
    .TAG_W(TAG_W), .MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_status(req_status),
    .iss_valid(iss_valid), .cpl_valid(cpl_valid), .cpl_ready(cpl_ready),
    .cpl_tag(cpl_tag), .cpl_data(cpl_data), .cpl_has_data(cpl_has_data),
    .cpl_local_hit(cpl_local_hit), .alias_count(alias_count)
);

// File: tb/ort_read_table_tb_top.sv
`timescale 1ns/1ps
module ort_read_table_tb_top;
    localparam int ADDR_W = 32;
    localparam int LINE_W = 28;
    localparam int TAG_W  = 6;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [2:0]        req_kind = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [2:0]        req_size = '0;
    logic [TAG_W-1:0]  req_tag = '0;
    logic [1:0]        req_status;
    logic              iss_valid;
    logic [LINE_W-1:0] iss_line;
    logic              iss_payload;
    logic              rsp_valid = 1'b0;
    logic              rsp_ready;
    logic [LINE_W-1:0] rsp_line = '0;
    logic [127:0]      rsp_data = '0;
    logic              rsp_external = 1'b0;
    logic              cpl_valid;
    logic              cpl_ready = 1'b1;
    logic [TAG_W-1:0]  cpl_tag;
    logic [31:0]       cpl_data;
    logic              cpl_has_data;
    logic              cpl_local_hit;
    logic [15:0]       alias_count;

    int checks = 0;
    int errors = 0;
    int exp_alias = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    ort_read_table dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
        .req_size(req_size), .req_tag(req_tag), .req_status(req_status),
        .iss_valid(iss_valid), .iss_line(iss_line), .iss_payload(iss_payload),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_line(rsp_line),
        .rsp_data(rsp_data), .rsp_external(rsp_external),
        .cpl_valid(cpl_valid), .cpl_ready(cpl_ready), .cpl_tag(cpl_tag),
        .cpl_data(cpl_data), .cpl_has_data(cpl_has_data),
        .cpl_local_hit(cpl_local_hit), .alias_count(alias_count)
    );

    function automatic logic [7:0] pat(int line, int k);
        return 8'((line * 7) ^ (k * 29) ^ 8'h5A);
    endfunction

    function automatic logic [127:0] line_bytes(int line);
        logic [127:0] d;
        for (int k = 0; k < 16; k++) d[k*8 +: 8] = pat(line, k);
        return d;
    endfunction

    function automatic logic [31:0] slice(int line, int off, int size);
        logic [31:0] s = '0;
        for (int j = 0; j < 4; j++) if (j < size) s[j*8 +: 8] = pat(line, off + j);
        return s;
    endfunction

    task automatic chk(bit ok, string rq, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
        end
    endtask

    // called just after a falling edge; returns after the next falling edge
    task automatic send_req(int kind, int line, int off, int size, int tag,
                            int exp_st, string rq);
        req_valid = 1'b1;
        req_kind  = 3'(kind);
        req_addr  = ADDR_W'((line << 4) | off);
        req_size  = 3'(size);
        req_tag   = TAG_W'(tag);
        #1;
        chk(req_status == 2'(exp_st), rq, "status", req_status, exp_st);
        chk(iss_valid == (exp_st == 0), rq, "iss_valid", iss_valid, exp_st == 0);
        if (exp_st == 0) begin
            chk(iss_line == LINE_W'(line), rq, "iss_line", iss_line, line);
            chk(iss_payload == (kind != 3), "R10", "iss_payload", iss_payload, kind != 3);
        end
        if (exp_st == 2) exp_alias++;
        @(negedge clk);
        req_valid = 1'b0;
        chk(alias_count == 16'(exp_alias), "R4", "alias_count", alias_count, exp_alias);
    endtask

    task automatic send_rsp(int line, bit ext);
        rsp_valid    = 1'b1;
        rsp_line     = LINE_W'(line);
        rsp_data     = line_bytes(line);
        rsp_external = ext;
        #1;
        chk(rsp_ready == 1'b1, "R13", "rsp_ready", rsp_ready, 1);
        @(negedge clk);
        rsp_valid = 1'b0;
    endtask

    task automatic take_cpl(int tag, int line, int off, int size, bit has, bit lh, string rq);
        for (int n = 0; n < 10 && !cpl_valid; n++) @(negedge clk);
        chk(cpl_valid == 1'b1, rq, "cpl_valid", cpl_valid, 1);
        chk(cpl_tag == TAG_W'(tag), "R7", "cpl_tag order", cpl_tag, tag);
        chk(cpl_data == (has ? slice(line, off, size) : 32'h0), rq, "cpl_data",
            cpl_data, has ? slice(line, off, size) : 32'h0);
        chk(cpl_has_data == has, "R10", "cpl_has_data", cpl_has_data, has);
        chk(cpl_local_hit == lh, "R9", "cpl_local_hit", cpl_local_hit, lh);
        cpl_ready = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk(cpl_valid == 1'b0, "R1", "cpl_valid", cpl_valid, 0);
        chk(rsp_ready == 1'b1, "R1", "rsp_ready", rsp_ready, 1);
        chk(alias_count == 16'h0, "R1", "alias_count", alias_count, 0);
    endtask

    task automatic t_stray;
        send_rsp(28'h777, 1'b0);
        for (int i = 0; i < 3; i++) begin
            chk(cpl_valid == 1'b0, "R13", "stray cpl_valid", cpl_valid, 0);
            @(negedge clk);
        end
    endtask

    task automatic t_merge_order;
        int a = 28'h40;
        send_req(2, a, 2, 4, 1, 0, "R2");
        send_req(2, a, 8, 2, 2, 1, "R3");
        send_req(2, a, 0, 1, 3, 1, "R3");
        send_rsp(a, 1'b0);
        cpl_ready = 1'b0;
        chk(cpl_valid && cpl_tag == 6'd1, "R7", "first held", cpl_tag, 1);
        chk(rsp_ready == 1'b0, "R13", "rsp_ready busy", rsp_ready, 0);
        send_req(2, a, 4, 1, 4, 2, "R12");
        chk(cpl_valid && cpl_tag == 6'd1, "R7", "still held", cpl_tag, 1);
        take_cpl(1, a, 2, 4, 1, 1, "R8");
        take_cpl(2, a, 8, 2, 1, 1, "R8");
        // last completion: request to the same line in the freeing cycle
        chk(cpl_valid && cpl_tag == 6'd3, "R7", "last tag", cpl_tag, 3);
        chk(cpl_data == slice(a, 0, 1), "R8", "last data", cpl_data, slice(a, 0, 1));
        send_req(0, a, 0, 4, 5, 2, "R11");
        send_req(0, a, 0, 4, 5, 0, "R11");
        send_rsp(a, 1'b1);
        take_cpl(5, a, 0, 4, 1, 0, "R8");
    endtask

    task automatic t_alias_types;
        int b = 28'h55;
        send_req(0, b, 4, 4, 6, 0, "R2");
        send_req(2, b, 4, 4, 7, 2, "R4");
        send_req(1, b, 0, 4, 8, 2, "R4");
        send_rsp(b, 1'b0);
        take_cpl(6, b, 4, 4, 1, 0, "R9");
        chk(cpl_valid == 1'b0, "R7", "single cpl", cpl_valid, 0);
    endtask

    task automatic t_dep_limit;
        int c = 28'h66;
        send_req(2, c, 0, 4, 10, 0, "R2");
        for (int d = 0; d < 4; d++) send_req(2, c, d + 1, d + 1, 11 + d, 1, "R5");
        send_req(2, c, 9, 2, 15, 2, "R5");
        send_rsp(c, 1'b1);
        take_cpl(10, c, 0, 4, 1, 0, "R5");
        for (int d = 0; d < 4; d++) take_cpl(11 + d, c, d + 1, d + 1, 1, 0, "R5");
        chk(cpl_valid == 1'b0, "R5", "after deps", cpl_valid, 0);
    endtask

    task automatic t_expose;
        send_req(3, 28'h300, 4, 4, 20, 0, "R10");
        send_req(4, 28'h301, 0, 2, 21, 0, "R10");
        send_rsp(28'h300, 1'b0);
        take_cpl(20, 28'h300, 4, 4, 0, 0, "R10");
        send_rsp(28'h301, 1'b0);
        take_cpl(21, 28'h301, 0, 2, 0, 0, "R10");
    endtask

    task automatic t_full;
        for (int i = 0; i < 8; i++) send_req(0, 28'h100 + i, 12, 4, 30 + i, 0, "R2");
        send_req(1, 28'h200, 0, 4, 40, 3, "R6");
        for (int i = 0; i < 8; i++) begin
            send_rsp(28'h100 + i, 1'b1);
            take_cpl(30 + i, 28'h100 + i, 12, 4, 1, 0, "R6");
        end
        send_req(1, 28'h200, 0, 4, 40, 0, "R6");
        send_rsp(28'h200, 1'b1);
        take_cpl(40, 28'h200, 0, 4, 1, 0, "R8");
    endtask

    initial begin
        #1000000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_stray();
        t_merge_order();
        t_alias_types();
        t_dep_limit();
        t_expose();
        t_full();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule